// File: doc/BRIEF.md
# Message Slot Transmit Status Controller

This block keeps the transmit-side state of a bank of sixteen message slots on a CAN node. Software arms a slot by setting its transmit-request flag through a small register port. Whenever the bus reports idle and no frame is in flight, the controller picks a slot that is armed and not yet finished. It marks that slot busy and tells an external frame engine to send it. The frame engine does all bit-level work and reports back only two things: arbitration was lost, or the frame was sent.

On an arbitration loss the slot drops back to waiting. It stays armed, so it competes again at the next idle point. On success the slot's sent flag rises, and the global status records success and the slot index. A success interrupt is raised if software has enabled it.

A slot cannot be re-armed while its sent flag is still set. Software clears both flags, reads them back as zero, and only then sets the request again.

Top module: `can_tx_mbox_ctrl`

## Requirements
- R1: After reset every slot flag, the global status word, the interrupt enable, `irq_o` and `eng_start_o` are all 0.
- R2: When `bus_idle_i` is 1, no frame is in flight and some slot has request=1, sent=0 and active=0, then on the next edge that slot's active flag and the global transmitting flag become 1. `eng_start_o` is high for exactly one cycle, and `eng_slot_o` carries the slot index.
- R3: When several slots are eligible at once, the lowest-numbered one is started.
- R4: `eng_arb_lost_i` during a frame clears the slot's active flag and the transmitting flag on the next edge. The request flag stays 1, so the same slot is started again at the next idle point.
- R5: `eng_done_i` during a frame (without `eng_arb_lost_i`) does the following on the next edge. It sets the slot's sent flag and clears its active flag and the transmitting flag. It sets the success flag and loads the 4-bit slot-number field with that slot's index. The success flag is cleared when the next frame starts.
- R6: A success raises `irq_o` for exactly one cycle, and sets a sticky pending bit, only when the enable bit is 1. Writing 1 to the pending bit clears it.
- R7: A write that tries to set a slot's request flag while that slot's sent flag is 1 leaves the request flag unchanged. A slot whose sent flag is 1 is never started.
- R8: No frame is started while one is in flight or while `bus_idle_i` is 0.
- R9: Register map (8-bit data).
  - Addresses 0..15 are the slots.
    - Write: bit0 is the new request value. bit1=0 clears the sent flag; bit1=1 keeps it.
    - Read: bit0 request, bit1 active, bit2 sent.
  - Address 16 is status.
    - Read: bit0 transmitting, bit1 success, bits5:2 slot number, bit6 interrupt pending.
    - Write: bit6=1 clears the pending bit.
  - Address 17 bit0 is the interrupt enable.
  - Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| bus_idle_i | input | 1 | Bus is idle; a frame may begin |
| eng_start_o | output | 1 | One-cycle start command to the frame engine |
| eng_slot_o | output | 4 | Index of the slot being sent |
| eng_arb_lost_i | input | 1 | Frame engine lost arbitration |
| eng_done_i | input | 1 | Frame engine finished sending successfully |
| irq_o | output | 1 | One-cycle success interrupt request |

## Verification
The properties assume the frame engine pulses `eng_arb_lost_i` or `eng_done_i` only while a frame is in flight, and never both in the same cycle. The bench drives these pulses only after it has seen `eng_start_o`, one at a time and for a single cycle. It also holds `bus_idle_i` low whenever it wants the bank to stay quiet, so that a slot armed by a write is not started before the check it belongs to.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int STAT_TXS_BIT  = 0;
  localparam int STAT_SUCC_BIT = 1;
  localparam int STAT_MBOX_LSB = 2;
  localparam int SLOT_REQ_BIT  = 0;
  localparam int SLOT_ACT_BIT  = 1;
  localparam int SLOT_SENT_BIT = 2;
  localparam int WR_KEEP_SENT_BIT = 1;
endpackage

// File: rtl/can_tx_slot_bank.sv
module can_tx_slot_bank #(
  parameter int N_SLOTS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] wr_sel_i,
  input  logic               wr_req_i,
  input  logic               wr_keep_sent_i,
  input  logic [N_SLOTS-1:0] launch_i,
  input  logic [N_SLOTS-1:0] lost_i,
  input  logic [N_SLOTS-1:0] done_i,
  output logic [N_SLOTS-1:0] req_o,
  output logic [N_SLOTS-1:0] active_o,
  output logic [N_SLOTS-1:0] sent_o,
  output logic [N_SLOTS-1:0] elig_o
);
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic req_q, act_q, sent_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q  <= 1'b0;
        act_q  <= 1'b0;
        sent_q <= 1'b0;
      end else begin
        // setting request is refused while sent is still up
        if (wr_sel_i[i]) begin
          if (!wr_req_i)    req_q <= 1'b0;
          else if (!sent_q) req_q <= 1'b1;
        end
        if (done_i[i])                          sent_q <= 1'b1;
        else if (wr_sel_i[i] && !wr_keep_sent_i) sent_q <= 1'b0;
        if (launch_i[i])                  act_q <= 1'b1;
        else if (lost_i[i] || done_i[i])  act_q <= 1'b0;
      end
    end

    assign req_o[i]    = req_q;
    assign active_o[i] = act_q;
    assign sent_o[i]   = sent_q;
    assign elig_o[i]   = req_q & ~sent_q & ~act_q;
  end
endmodule

// File: rtl/can_tx_prio_pick.sv
module can_tx_prio_pick #(
  parameter int N_SLOTS = 16,
  parameter int IDX_W   = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_tx_seq.sv
module can_tx_seq #(
  parameter int N_SLOTS = 16,
  parameter int IDX_W   = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_idle_i,
  input  logic               any_i,
  input  logic [IDX_W-1:0]   pick_i,
  input  logic               arb_lost_i,
  input  logic               done_i,
  input  logic               ien_i,
  input  logic               pend_clr_i,
  output logic               tx_state_o,
  output logic [IDX_W-1:0]   cur_o,
  output logic               start_o,
  output logic               succ_o,
  output logic [IDX_W-1:0]   mbox_o,
  output logic               irq_o,
  output logic               pend_o,
  output logic [N_SLOTS-1:0] launch_vec_o,
  output logic [N_SLOTS-1:0] lost_vec_o,
  output logic [N_SLOTS-1:0] done_vec_o
);
  logic start_go, lost_ev, done_ev;

  assign start_go = !tx_state_o && bus_idle_i && any_i;
  assign lost_ev  = tx_state_o && arb_lost_i;
  assign done_ev  = tx_state_o && done_i && !arb_lost_i;

  assign launch_vec_o = start_go ? (N_SLOTS'(1) << pick_i) : '0;
  assign lost_vec_o   = lost_ev  ? (N_SLOTS'(1) << cur_o)  : '0;
  assign done_vec_o   = done_ev  ? (N_SLOTS'(1) << cur_o)  : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_state_o <= 1'b0;
      cur_o      <= '0;
      start_o    <= 1'b0;
      succ_o     <= 1'b0;
      mbox_o     <= '0;
      irq_o      <= 1'b0;
      pend_o     <= 1'b0;
    end else begin
      start_o <= start_go;
      irq_o   <= done_ev && ien_i;
      if (start_go) begin
        tx_state_o <= 1'b1;
        cur_o      <= pick_i;
        succ_o     <= 1'b0;
      end else if (lost_ev || done_ev) begin
        tx_state_o <= 1'b0;
      end
      if (done_ev) begin
        succ_o <= 1'b1;
        mbox_o <= cur_o;
      end
      if (done_ev && ien_i) pend_o <= 1'b1;
      else if (pend_clr_i)  pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_tx_mbox_ctrl.sv
module can_tx_mbox_ctrl #(
  parameter int N_SLOTS = 16,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(N_SLOTS),
  localparam int ADDR_W = $clog2(N_SLOTS + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              bus_idle_i,
  output logic              eng_start_o,
  output logic [IDX_W-1:0]  eng_slot_o,
  input  logic              eng_arb_lost_i,
  input  logic              eng_done_i,
  output logic              irq_o
);
  import can_tx_pkg::*;

  localparam int STAT_PEND_BIT = STAT_MBOX_LSB + IDX_W;
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(N_SLOTS);
  localparam logic [ADDR_W-1:0] ADDR_IEN  = ADDR_W'(N_SLOTS + 1);

  logic [N_SLOTS-1:0] wr_sel, launch_vec, lost_vec, done_vec;
  logic [N_SLOTS-1:0] req_vec, active_vec, sent_vec, elig_vec;
  logic               any_elig, tx_state, succ, pend, ien_q, pend_clr;
  logic [IDX_W-1:0]   pick, mbox;
  logic [IDX_W-1:0]   rd_slot;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_dec
    assign wr_sel[i] = reg_we_i && (reg_addr_i == ADDR_W'(i));
  end

  assign pend_clr = reg_we_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[STAT_PEND_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ien_q <= 1'b0;
    else if (reg_we_i && reg_addr_i == ADDR_IEN) ien_q <= reg_wdata_i[0];
  end

  can_tx_slot_bank #(.N_SLOTS(N_SLOTS)) u_bank (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_sel_i       (wr_sel),
    .wr_req_i       (reg_wdata_i[0]),
    .wr_keep_sent_i (reg_wdata_i[WR_KEEP_SENT_BIT]),
    .launch_i       (launch_vec),
    .lost_i         (lost_vec),
    .done_i         (done_vec),
    .req_o          (req_vec),
    .active_o       (active_vec),
    .sent_o         (sent_vec),
    .elig_o         (elig_vec)
  );

  can_tx_prio_pick #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_pick (
    .req_i (elig_vec),
    .any_o (any_elig),
    .idx_o (pick)
  );

  can_tx_seq #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_idle_i   (bus_idle_i),
    .any_i        (any_elig),
    .pick_i       (pick),
    .arb_lost_i   (eng_arb_lost_i),
    .done_i       (eng_done_i),
    .ien_i        (ien_q),
    .pend_clr_i   (pend_clr),
    .tx_state_o   (tx_state),
    .cur_o        (eng_slot_o),
    .start_o      (eng_start_o),
    .succ_o       (succ),
    .mbox_o       (mbox),
    .irq_o        (irq_o),
    .pend_o       (pend),
    .launch_vec_o (launch_vec),
    .lost_vec_o   (lost_vec),
    .done_vec_o   (done_vec)
  );

  assign rd_slot = reg_addr_i[IDX_W-1:0];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < ADDR_STAT) begin
      reg_rdata_o[SLOT_REQ_BIT]  = req_vec[rd_slot];
      reg_rdata_o[SLOT_ACT_BIT]  = active_vec[rd_slot];
      reg_rdata_o[SLOT_SENT_BIT] = sent_vec[rd_slot];
    end else if (reg_addr_i == ADDR_STAT) begin
      reg_rdata_o[STAT_TXS_BIT]                    = tx_state;
      reg_rdata_o[STAT_SUCC_BIT]                   = succ;
      reg_rdata_o[STAT_MBOX_LSB +: IDX_W]          = mbox;
      reg_rdata_o[STAT_PEND_BIT]                   = pend;
    end else if (reg_addr_i == ADDR_IEN) begin
      reg_rdata_o[0] = ien_q;
    end
  end
endmodule

// File: rtl/can_tx_mbox_chk.sv
module can_tx_mbox_chk #(
  parameter int N_SLOTS = 16,
  parameter int IDX_W   = $clog2(N_SLOTS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_idle_i,
  input logic               eng_start_o,
  input logic [IDX_W-1:0]   eng_slot_o,
  input logic               eng_arb_lost_i,
  input logic               eng_done_i,
  input logic               irq_o,
  input logic               tx_state,
  input logic               ien_q,
  input logic [N_SLOTS-1:0] req_vec,
  input logic [N_SLOTS-1:0] active_vec,
  input logic [N_SLOTS-1:0] sent_vec
);
  logic [N_SLOTS-1:0] slot_mask, low_mask;
  assign slot_mask = N_SLOTS'(1) << eng_slot_o;
  assign low_mask  = slot_mask - N_SLOTS'(1);

  a_r2_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  a_r2_start_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (tx_state && active_vec == slot_mask));
  a_r3_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (($past(req_vec & ~sent_vec & ~active_vec) & low_mask) == '0));
  a_r4_lost_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_state && eng_arb_lost_i) |=> (!tx_state && active_vec == '0));
  a_r5_done_sets_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_state && eng_done_i && !eng_arb_lost_i) |=> (!tx_state && (sent_vec & slot_mask) != '0));
  a_r6_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ien_q));
  a_r6_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r7_sent_not_started: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (($past(sent_vec) & slot_mask) == '0));
  a_r8_start_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (!$past(tx_state) && $past(bus_idle_i)));
  a_r2_single_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(active_vec) <= 1);
endmodule

bind can_tx_mbox_ctrl can_tx_mbox_chk #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bus_idle_i     (bus_idle_i),
  .eng_start_o    (eng_start_o),
  .eng_slot_o     (eng_slot_o),
  .eng_arb_lost_i (eng_arb_lost_i),
  .eng_done_i     (eng_done_i),
  .irq_o          (irq_o),
  .tx_state       (tx_state),
  .ien_q          (ien_q),
  .req_vec        (req_vec),
  .active_vec     (active_vec),
  .sent_vec       (sent_vec)
);

// File: tb/tb_can_tx_mbox_ctrl.sv
module tb_can_tx_mbox_ctrl;
  localparam int NS = 16;
  localparam logic [4:0] A_STAT = 5'd16;
  localparam logic [4:0] A_IEN  = 5'd17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       idle = 1'b0;
  logic       start;
  logic [3:0] slot;
  logic       lost = 1'b0;
  logic       done = 1'b0;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  can_tx_mbox_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bus_idle_i(idle),
    .eng_start_o(start), .eng_slot_o(slot), .eng_arb_lost_i(lost),
    .eng_done_i(done), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string req);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  function automatic int stat_val(int txs, int succ, int mbox, int pend);
    return txs + (succ << 1) + (mbox << 2) + (pend << 6);
  endfunction

  // pulse bus idle, expect a start of slot exp
  task automatic launch(input int exp, input string req);
    int v;
    idle = 1'b1;
    tick();
    idle = 1'b0;
    chk(int'(start), 1, req);
    chk(int'(slot), exp, req);
    rd(5'(exp), v);
    chk(v, 3, req);                     // req=1 active=1 sent=0
    rd(A_STAT, v);
    chk(v & 3, 1, req);                 // transmitting, success cleared
    tick();
    chk(int'(start), 0, "R2");
  endtask

  task automatic finish_ok();
    done = 1'b1;
    tick();
    done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < NS + 2; a++) begin
      rd(5'(a), v);
      chk(v, 0, "R1");
    end
    chk(int'(irq), 0, "R1");
    chk(int'(start), 0, "R1");
    rst_n = 1'b1;
    tick();

    // R2 R5 R6 sweep over every slot, enable alternating
    for (int i = 0; i < NS; i++) begin
      int en;
      en = (i % 2 == 0) ? 1 : 0;
      wr(A_IEN, 8'(en));
      wr(5'(i), 8'h01);
      chk(int'(start), 0, "R8");        // bus not idle: nothing started
      launch(i, "R2");
      finish_ok();
      chk(int'(irq), en, "R6");
      rd(5'(i), v);
      chk(v, 5, "R5");                  // req=1 active=0 sent=1
      rd(A_STAT, v);
      chk(v, stat_val(0, 1, i, en), "R5");
      tick();
      chk(int'(irq), 0, "R6");
      // R7 sent slot with request still set is not restarted
      idle = 1'b1;
      tick();
      idle = 1'b0;
      chk(int'(start), 0, "R7");
      if (en == 1) begin
        wr(A_STAT, 8'h40);
        rd(A_STAT, v);
        chk(v, stat_val(0, 1, i, 0), "R6");
      end
      wr(5'(i), 8'h00);
      rd(5'(i), v);
      chk(v, 0, "R9");
    end

    // R7 set request refused while sent is 1
    wr(A_IEN, 8'h00);
    wr(5'd5, 8'h01);
    launch(5, "R7");
    finish_ok();
    wr(5'd5, 8'h02);                    // drop request, keep sent
    rd(5'd5, v);
    chk(v, 4, "R7");
    wr(5'd5, 8'h03);                    // try to re-arm with sent up
    rd(5'd5, v);
    chk(v, 4, "R7");
    idle = 1'b1;
    tick();
    idle = 1'b0;
    chk(int'(start), 0, "R7");
    wr(5'd5, 8'h00);
    rd(5'd5, v);
    chk(v, 0, "R7");
    wr(5'd5, 8'h01);
    launch(5, "R7");
    finish_ok();
    wr(5'd5, 8'h00);

    // R3 priority order
    wr(5'd12, 8'h01);
    wr(5'd7, 8'h01);
    wr(5'd3, 8'h01);
    launch(3, "R3");
    // R8 no start while in flight even with bus idle
    idle = 1'b1;
    tick();
    tick();
    idle = 1'b0;
    chk(int'(start), 0, "R8");
    finish_ok();
    launch(7, "R3");
    finish_ok();
    launch(12, "R3");
    finish_ok();
    rd(A_STAT, v);
    chk(v, stat_val(0, 1, 12, 0), "R5");
    wr(5'd3, 8'h00);
    wr(5'd7, 8'h00);
    wr(5'd12, 8'h00);

    // R4 arbitration loss, retry same slot
    wr(5'd9, 8'h01);
    wr(5'd14, 8'h01);
    launch(9, "R4");
    lost = 1'b1;
    tick();
    lost = 1'b0;
    chk(int'(irq), 0, "R4");
    rd(5'd9, v);
    chk(v, 1, "R4");                    // still requesting, not active
    rd(A_STAT, v);
    chk(v & 1, 0, "R4");
    launch(9, "R4");
    finish_ok();
    launch(14, "R3");
    finish_ok();
    rd(A_STAT, v);
    chk(v, stat_val(0, 1, 14, 0), "R5");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule